// File: doc/BRIEF.md
# Power-Down and Self-Calibration Sequencer

This block watches a single control pin that plays two roles. While the pin is high, the block holds power-down, disables the high-speed clock outputs and masks the loss-of-lock indication. When the pin goes low after a long enough high period, the block starts a fixed sequence. It first resets the digital state for a fixed number of cycles. It then waits for a valid reference clock and starts calibration with a one-cycle strobe. After calibration it waits for acquisition to finish. Only then does it enable the outputs and unmask the lock indication.

The pin is asynchronous. It passes through a synchronizer into the system clock domain. A counter there measures how long the pin stays high, and a falling edge that arrives too early is ignored. The calibration engine is outside this block. The engine reports the end of calibration, and later the end of acquisition, with a one-cycle done strobe. If no strobe arrives during acquisition, a timeout ends acquisition after a fixed number of cycles.

Top module: `pdcal_seq`

## Requirements
- R1: After rst_n is released, the block is in power-down: out_en=0, busy=0, logic_rst=0, cal_start=0, lol_mask=1.
- R2: The pin is synchronized through SYNC_STAGES flops. Once the pin is high, the block enters power-down from any state on the (SYNC_STAGES+1)-th rising clock edge, with out_en=0 and busy=0.
- R3: A falling edge starts the sequence only if the pin was sampled high on at least MIN_HIGH_CYC consecutive clock edges. A shorter high period is ignored: the block stays in power-down with busy=0 and logic_rst=0.
- R4: The sequence begins with logic_rst=1 for exactly RST_CYC cycles. During those cycles busy=1, out_en=0 and cal_start=0.
- R5: After the reset step, while ref_ok=0, the block waits with busy=1 and cal_start=0.
- R6: cal_start is a one-cycle pulse. It goes high in the first calibration cycle, which follows a cycle in which ref_ok=1.
- R7: If ref_ok drops during calibration, the block returns to waiting. A cal_done strobe during that wait has no effect. When ref_ok returns, a new cal_start pulse is issued.
- R8: A cal_done strobe during calibration moves the block to acquisition. Acquisition ends on the next cal_done strobe, or after ACQ_TIMEOUT cycles if none arrives.
- R9: In normal operation, out_en=1, busy=0 and lol_mask=0. In every other state, out_en=0 and lol_mask=1. busy=1 exactly in the reset, wait, calibration and acquisition steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pd_pin | input | 1 | Power-down/calibrate pin, asynchronous, high means power-down |
| ref_ok | input | 1 | Reference clock valid (level) |
| cal_done | input | 1 | One-cycle strobe from the calibration engine |
| out_en | output | 1 | High-speed clock output enable |
| logic_rst | output | 1 | Reset for the digital loop state |
| cal_start | output | 1 | One-cycle calibration start pulse |
| busy | output | 1 | Reset/calibration/acquisition sequence in progress |
| lol_mask | output | 1 | Suppresses the loss-of-lock indication |

## Verification
The assertions take ref_ok to be a level that is meaningful in every cycle, so that the reference check on each calibration pulse is sound. They take cal_done to be a strobe the block may see in any state, with effects only in calibration and acquisition. The pin is observed only after the synchronizer, so the power-down property relates the synchronized level to the next cycle's outputs. The stimulus changes inputs only on falling clock edges and gives cal_done one cycle at a time. It holds the pin high for exact cycle counts, so the qualification boundary is reached from both sides.

// File: rtl/pdcal_seq.sv
module pdcal_seq #(
  parameter int MIN_HIGH_CYC = 200,
  parameter int RST_CYC      = 16,
  parameter int ACQ_TIMEOUT  = 290000,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pd_pin,
  input  logic ref_ok,
  input  logic cal_done,
  output logic out_en,
  output logic logic_rst,
  output logic cal_start,
  output logic busy,
  output logic lol_mask
);
  localparam int HW   = $clog2(MIN_HIGH_CYC + 1);
  localparam int CMAX = (ACQ_TIMEOUT > RST_CYC) ? ACQ_TIMEOUT : RST_CYC;
  localparam int CW   = $clog2(CMAX + 1);

  typedef enum logic [2:0] {S_PDN, S_RST, S_WREF, S_CAL, S_ACQ, S_RUN} st_t;

  st_t st, nx;
  logic [SYNC_STAGES-1:0] sync;
  logic [HW-1:0] hi_cnt;
  logic [CW-1:0] cnt;
  logic pin_s, qual, rst_last, acq_last;

  assign pin_s    = sync[SYNC_STAGES-1];
  assign qual     = (hi_cnt == HW'(MIN_HIGH_CYC));
  assign rst_last = (cnt == CW'(RST_CYC - 1));
  assign acq_last = (cnt == CW'(ACQ_TIMEOUT - 1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync <= '1;
    else        sync <= {sync[SYNC_STAGES-2:0], pd_pin};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      hi_cnt <= '0;
    else if (!pin_s) hi_cnt <= '0;
    else if (!qual)  hi_cnt <= hi_cnt + HW'(1);

  always_comb begin
    nx = st;
    if (pin_s) nx = S_PDN;
    else begin
      case (st)
        S_PDN:   if (qual) nx = S_RST;
        S_RST:   if (rst_last) nx = S_WREF;
        S_WREF:  if (ref_ok) nx = S_CAL;
        S_CAL:   if (!ref_ok) nx = S_WREF;
                 else if (cal_done) nx = S_ACQ;
        S_ACQ:   if (cal_done || acq_last) nx = S_RUN;
        default: nx = st;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st        <= S_PDN;
      cnt       <= '0;
      cal_start <= 1'b0;
    end else begin
      st        <= nx;
      cal_start <= (nx == S_CAL) && (st != S_CAL);
      if (nx != st)                cnt <= '0;
      else if (cnt != CW'(CMAX))   cnt <= cnt + CW'(1);
    end

  assign out_en    = (st == S_RUN);
  assign logic_rst = (st == S_RST);
  assign busy      = (st == S_RST) || (st == S_WREF) || (st == S_CAL) || (st == S_ACQ);
  assign lol_mask  = (st != S_RUN);
endmodule

// File: rtl/pdcal_seq_chk.sv
module pdcal_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic pin_s,
  input logic ref_ok,
  input logic out_en,
  input logic logic_rst,
  input logic cal_start,
  input logic busy,
  input logic lol_mask
);
  // R9
  en_busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(out_en && busy));
  // R9
  run_unmask_chk: assert property (@(posedge clk) disable iff (!rst_n) out_en |-> !lol_mask);
  // R9
  busy_mask_chk: assert property (@(posedge clk) disable iff (!rst_n) busy |-> lol_mask);
  // R6
  cal_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) cal_start |=> !cal_start);
  // R6
  cal_ref_chk: assert property (@(posedge clk) disable iff (!rst_n) cal_start |-> $past(ref_ok));
  // R2
  pd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) pin_s |=> (!out_en && !busy));
  // R8
  run_entry_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(out_en) |-> $past(busy));
  // R4
  rst_step_chk: assert property (@(posedge clk) disable iff (!rst_n) logic_rst |-> (busy && !out_en && !cal_start));
endmodule

bind pdcal_seq pdcal_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pin_s(pin_s), .ref_ok(ref_ok),
  .out_en(out_en), .logic_rst(logic_rst), .cal_start(cal_start),
  .busy(busy), .lol_mask(lol_mask)
);

// File: tb/sim_pdcal_seq.sv
`timescale 1ns/1ps
module sim_pdcal_seq;
  localparam int MINH = 8, RSTC = 4, ACQ = 40;
  logic clk = 1'b0, rst_n = 1'b0, pd_pin = 1'b0, ref_ok = 1'b1, cal_done = 1'b0;
  logic out_en, logic_rst, cal_start, busy, lol_mask;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pdcal_seq #(.MIN_HIGH_CYC(MINH), .RST_CYC(RSTC), .ACQ_TIMEOUT(ACQ), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .pd_pin(pd_pin), .ref_ok(ref_ok), .cal_done(cal_done),
    .out_en(out_en), .logic_rst(logic_rst), .cal_start(cal_start), .busy(busy), .lol_mask(lol_mask));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic sel(input int k);
    case (k)
      0: sel = logic_rst;
      1: sel = cal_start;
      2: sel = out_en;
      default: sel = busy;
    endcase
  endfunction

  task automatic wait_hi(input int k, input int lim, output int n);
    n = 0;
    while (!sel(k) && n < lim) begin @(negedge clk); n++; end
  endtask

  task automatic press(input int h);
    @(negedge clk); pd_pin = 1'b1;
    repeat (h) @(negedge clk);
    pd_pin = 1'b0;
  endtask

  task automatic strobe_done;
    cal_done = 1'b1; @(negedge clk); cal_done = 1'b0;
  endtask

  // reaches the first calibration cycle (cal_start seen), ref_ok assumed high
  task automatic to_cal(input string req);
    int n;
    press(MINH);
    wait_hi(1, 40, n);
    chk(cal_start === 1'b1, req, cal_start, 1);
  endtask

  task automatic t_reset;
    chk(out_en === 1'b0 && busy === 1'b0 && logic_rst === 1'b0 && cal_start === 1'b0, "R1 outputs", {out_en, busy, logic_rst, cal_start}, 0);
    chk(lol_mask === 1'b1, "R1 lol_mask", lol_mask, 1);
  endtask

  task automatic t_short;
    int seen = 0;
    press(MINH - 1);
    repeat (20) begin @(negedge clk); if (logic_rst || busy) seen++; end
    chk(seen == 0, "R3 short press ignored", seen, 0);
    chk(lol_mask === 1'b1 && out_en === 1'b0, "R3 stays in power-down", out_en, 0);
  endtask

  task automatic t_full;
    int n, w;
    press(MINH);
    wait_hi(0, 20, n);
    chk(logic_rst === 1'b1, "R3 exact-minimum press starts sequence", logic_rst, 1);
    w = 0;
    while (logic_rst && w < 50) begin
      if (!busy || out_en || cal_start) w += 100;
      w++; @(negedge clk);
    end
    chk(w == RSTC, "R4 reset step length", w, RSTC);
    chk(busy === 1'b1 && cal_start === 1'b0, "R5 wait step", busy, 1);
    @(negedge clk);
    chk(cal_start === 1'b1, "R6 cal_start after ref present", cal_start, 1);
    @(negedge clk);
    chk(cal_start === 1'b0, "R6 cal_start one cycle", cal_start, 0);
    strobe_done;
    chk(busy === 1'b1 && out_en === 1'b0 && lol_mask === 1'b1, "R9 acquisition masked", lol_mask, 1);
    strobe_done;
    chk(out_en === 1'b1 && busy === 1'b0, "R8 early end of acquisition", out_en, 1);
    chk(lol_mask === 1'b0, "R9 run unmasks", lol_mask, 0);
  endtask

  task automatic t_pd_run;
    @(negedge clk); pd_pin = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(out_en === 1'b1, "R2 sync latency not yet", out_en, 1);
    @(negedge clk);
    chk(out_en === 1'b0 && busy === 1'b0 && lol_mask === 1'b1, "R2 power-down from run", out_en, 0);
    repeat (MINH) @(negedge clk);
    pd_pin = 1'b0;
  endtask

  task automatic t_timeout;
    int n;
    wait_hi(1, 40, n);
    chk(cal_start === 1'b1, "R8 sequence after held press", cal_start, 1);
    strobe_done;
    n = 0;
    while (busy && n < 1000) begin n++; @(negedge clk); end
    chk(n == ACQ, "R8 acquisition timeout", n, ACQ);
    chk(out_en === 1'b1, "R8 run after timeout", out_en, 1);
  endtask

  task automatic t_wait_ref;
    int n, bad = 0;
    ref_ok = 1'b0;
    press(MINH);
    wait_hi(0, 20, n);
    while (logic_rst) @(negedge clk);
    repeat (10) begin if (!busy || cal_start) bad++; @(negedge clk); end
    chk(bad == 0, "R5 waits without reference", bad, 0);
    ref_ok = 1'b1;
    @(negedge clk);
    chk(cal_start === 1'b1, "R6 cal_start when reference valid", cal_start, 1);
  endtask

  task automatic t_ref_drop;
    ref_ok = 1'b0;
    @(negedge clk);
    chk(cal_start === 1'b0 && busy === 1'b1, "R7 back to wait", busy, 1);
    strobe_done;
    repeat (3) @(negedge clk);
    chk(out_en === 1'b0 && busy === 1'b1, "R7 cal_done ignored while waiting", out_en, 0);
    ref_ok = 1'b1;
    @(negedge clk);
    chk(cal_start === 1'b1, "R7 new cal_start on reference return", cal_start, 1);
    @(negedge clk);
    strobe_done;
    strobe_done;
    chk(out_en === 1'b1, "R8 run after two strobes", out_en, 1);
  endtask

  task automatic t_pd_cal;
    to_cal("R6 cal_start before abort");
    pd_pin = 1'b1;
    repeat (4) @(negedge clk);
    chk(busy === 1'b0 && cal_start === 1'b0 && lol_mask === 1'b1, "R2 power-down from calibration", busy, 0);
    repeat (MINH) @(negedge clk);
    pd_pin = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_short;
    t_full;
    t_pd_run;
    t_timeout;
    t_wait_ref;
    t_ref_drop;
    t_pd_cal;
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin @(posedge clk); cyc++; end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule